// File: doc/BRIEF.md
# Debug Status Scan Register with Sticky Overflow Flags

This block is a 16-bit data register that sits behind a test access port and is read and written in the same scan. The port controller drives three level strobes: capture, shift and update. Each strobe is high for one TCK cycle in the matching state. The register also takes a serial input and drives a serial output. On capture, the current status word is loaded into the shift stage. On update, the word that was shifted in is applied to the register.

Two bits of the word are sticky overflow flags. One is for the data-in path and one is for the data-out path. Core logic raises them with single-cycle event pulses in its own clock domain. Each pulse is turned into a toggle, brought into the TCK domain through a two-flop chain, and edge-detected there. A flag clears only when a 1 lands in its position at update. A 0 in that position leaves it alone. The fourteen upper bits carry a core status vector and cannot be written. A debugger that wants to read without clearing must therefore shift zeros into the two low positions.

Top module: `dbg_stat_scan_reg`

## Requirements
- R1: On a TCK edge with `capture_dr` high, the shift stage loads this word: bits 15..2 take `core_status[13:0]`, bit 1 takes the data-out overflow flag, and bit 0 takes the data-in overflow flag.
- R2: On a TCK edge with `shift_dr` high, the stage moves one place toward the MSB and `tdi` enters bit 0. `tdo` always shows bit 15, so the word leaves MSB first and the LSB is the last bit shifted in.
- R3: On a TCK edge with `update_dr` high, a 1 in shifted bit 0 clears the data-in flag and a 1 in shifted bit 1 clears the data-out flag.
- R4: A 0 in a sticky position at update leaves that flag unchanged. Written bits 15..2 have no effect on what later captures return.
- R5: A pulse on `ovf_evt[0]` sets the data-in flag and a pulse on `ovf_evt[1]` sets the data-out flag. Each pulse must be high for one `core_clk` edge. The flag is set on the third TCK rising edge after that core edge, and it stays set until it is cleared.
- R6: If a flag's set and its clear fall on the same TCK edge, the flag ends up set.
- R7: Reset clears both flags and the shift stage, so `tdo` reads 0. Reset is synchronous and active low: `rst_n` for the TCK side and `core_rst_n` for the core side.
- R8: With no strobe high, the shift stage holds its contents and `tdo` stays stable. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset, TCK domain |
| capture_dr | input | 1 | Capture strobe from the port controller |
| shift_dr | input | 1 | Shift strobe from the port controller |
| update_dr | input | 1 | Update strobe from the port controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 15 of the shift stage) |
| core_clk | input | 1 | Core clock for the event pulses |
| core_rst_n | input | 1 | Synchronous active-low reset, core domain |
| core_status | input | 14 | Read-only status bits, sampled at capture |
| ovf_evt | input | 2 | Overflow event pulses: bit 0 data-in, bit 1 data-out |

## Verification
The hardest case to reach from the ports is a synchronized set pulse landing on the very TCK edge where update clears the same flag. The events cross clock domains, so there is only a three-edge window in which to aim.

The bench runs the core clock at a fixed phase offset from TCK. This makes the crossing latency exact. It then fires an event during a clearing scan, placed one edge before update, exactly on update, and one edge after. A later zero-write read checks the flag. The expected results are cleared, set and set.

// File: rtl/dss_pkg.sv
// Package: shared constants for the debug status scan register.
// It fixes the default register length, the number of sticky flags,
// the synchronizer depth, and the bit index of each flag.
package dss_pkg;
    localparam int unsigned DSS_DR_W     = 16;
    localparam int unsigned DSS_STICKY_N = 2;
    localparam int unsigned DSS_SYNC_N   = 2;

    typedef enum int unsigned {
        FLAG_DIN_OVF  = 0,
        FLAG_DOUT_OVF = 1
    } dss_flag_e;
endpackage

// File: rtl/dss_evt_sync.sv
// Event pulse synchronizer.
// A pulse held for one source-clock edge flips a toggle in the source domain.
// A chain of STAGES flops carries the toggle into the destination domain.
// An edge detector there turns each change into one destination-cycle pulse.
// Assumptions: STAGES >= 2. Source pulses are spaced widely enough that the
// destination clock sees every toggle level. Both resets are asserted together.
module dss_evt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              src_tgl;
    logic [STAGES-1:0] chain;
    logic              last;

    // Flip the toggle once for each accepted source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)     src_tgl <= 1'b0;
        else if (src_pulse) src_tgl <= ~src_tgl;
    end

    // Carry the toggle through the chain and keep the previous synced level.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], src_tgl};
            last  <= chain[STAGES-1];
        end
    end

    assign dst_pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/dss_sticky_bit.sv
// One sticky flag.
// set_i raises the flag and clr_i lowers it. When both are high on the same
// edge, set_i wins. Otherwise the flag holds.
// Assumption: set_i and clr_i are synchronous to clk.
module dss_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    // R6: a set and a clear together leave the flag set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);
    // R5: a set event always leaves the flag raised
    p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R3: a lone clear lowers the flag
    p_clear_lowers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R4: with neither set nor clear, the flag keeps its value
    p_flag_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
    // R7: reset empties the flag
    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> !flag_o);
endmodule

// File: rtl/dss_shift_stage.sv
// Capture/shift stage of the scan register.
// Capture loads load_i in parallel. Shift moves the word toward the MSB with
// sdi entering bit 0. sdo shows the MSB. low_o exposes the lowest KEEP_W bits
// for use at update.
// Assumption: at most one of cap_i and shift_i is high in any cycle.
module dss_shift_stage #(
    parameter int unsigned W      = 16,
    parameter int unsigned KEEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic [W-1:0]      load_i,
    input  logic              sdi,
    output logic              sdo,
    output logic [KEEP_W-1:0] low_o
);
    logic [W-1:0] sh;

    // Shift register: parallel load on capture, MSB-ward shift on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh <= '0;
        else if (cap_i)   sh <= load_i;
        else if (shift_i) sh <= {sh[W-2:0], sdi};
    end

    assign sdo   = sh[W-1];
    assign low_o = sh[KEEP_W-1:0];

    // R1: capture takes the presented status word
    p_capture_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (sh == $past(load_i)));
    // R2: shift moves one place toward the MSB, serial input at bit 0
    p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !cap_i) |=> (sh == {$past(sh[W-2:0]), $past(sdi)}));
    // R8: with no strobe the stage holds
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i && !shift_i) |=> $stable(sh));
endmodule

// File: rtl/dbg_stat_scan_reg.sv
// Debug status scan register (top).
// Builds the capture word from the core status vector and the sticky flags.
// Connects the shift stage to the serial pins. At update, turns ones in the
// low shifted bits into clears for the matching flags. Core-side event pulses
// reach the flags through per-flag synchronizers.
// Assumptions: strobes come from a port controller and are mutually exclusive.
// core_status is quasi-static while a capture can occur.
module dbg_stat_scan_reg
    import dss_pkg::*;
#(
    parameter int unsigned DR_W     = DSS_DR_W,
    parameter int unsigned STICKY_N = DSS_STICKY_N,
    parameter int unsigned SYNC_N   = DSS_SYNC_N
) (
    input  logic                     tck,
    input  logic                     rst_n,
    input  logic                     capture_dr,
    input  logic                     shift_dr,
    input  logic                     update_dr,
    input  logic                     tdi,
    output logic                     tdo,
    input  logic                     core_clk,
    input  logic                     core_rst_n,
    input  logic [DR_W-STICKY_N-1:0] core_status,
    input  logic [STICKY_N-1:0]      ovf_evt
);
    localparam int unsigned STAT_W = DR_W - STICKY_N;

    logic [STICKY_N-1:0] flags;
    logic [STICKY_N-1:0] set_pulse;
    logic [STICKY_N-1:0] clr_req;
    logic [STICKY_N-1:0] shifted_low;
    logic [DR_W-1:0]     cap_word;

    // Capture word: status above, flags in the low positions.
    assign cap_word = {core_status[STAT_W-1:0], flags};
    // Update: every 1 shifted into a sticky position asks to clear that flag.
    assign clr_req  = update_dr ? shifted_low : '0;

    dss_shift_stage #(
        .W      (DR_W),
        .KEEP_W (STICKY_N)
    ) u_stage (
        .clk     (tck),
        .rst_n   (rst_n),
        .cap_i   (capture_dr),
        .shift_i (shift_dr),
        .load_i  (cap_word),
        .sdi     (tdi),
        .sdo     (tdo),
        .low_o   (shifted_low)
    );

    // One synchronizer and one sticky bit per overflow flag.
    for (genvar gi = 0; gi < STICKY_N; gi++) begin : g_flag
        dss_evt_sync #(
            .STAGES (SYNC_N)
        ) u_sync (
            .src_clk   (core_clk),
            .src_rst_n (core_rst_n),
            .src_pulse (ovf_evt[gi]),
            .dst_clk   (tck),
            .dst_rst_n (rst_n),
            .dst_pulse (set_pulse[gi])
        );

        dss_sticky_bit u_bit (
            .clk    (tck),
            .rst_n  (rst_n),
            .set_i  (set_pulse[gi]),
            .clr_i  (clr_req[gi]),
            .flag_o (flags[gi])
        );
    end

    // R8: the controller never raises two strobes at once
    p_strobe_excl_r8: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({capture_dr, shift_dr, update_dr}));
    // R7: reset leaves the serial output low
    p_reset_tdo_r7: assert property (@(posedge tck)
        !rst_n |=> !tdo);
endmodule

// File: tb/dbg_stat_scan_reg_tb.sv
// Directed bench for the debug status scan register.
// TCK runs at 50 MHz. The core clock has the same period, with its rising
// edge 15 ns after each TCK falling edge, so the crossing latency is exact.
// Inputs change on TCK falling edges.
module dbg_stat_scan_reg_tb;
    logic        tck = 1'b0;
    logic        core_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_rst_n = 1'b0;
    logic        cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [13:0] status = '0;
    logic [1:0]  evt = '0;

    int checks = 0;
    int errors = 0;

    dbg_stat_scan_reg u_dut (
        .tck         (tck),
        .rst_n       (rst_n),
        .capture_dr  (cap),
        .shift_dr    (shf),
        .update_dr   (upd),
        .tdi         (tdi),
        .tdo         (tdo),
        .core_clk    (core_clk),
        .core_rst_n  (core_rst_n),
        .core_status (status),
        .ovf_evt     (evt)
    );

    always #10 tck = ~tck;
    initial begin
        #15;
        forever begin
            core_clk = 1'b1; #10;
            core_clk = 1'b0; #10;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            cap = 0; shf = 0; upd = 0; evt = '0;
        end
    endtask

    // Full capture/shift/update scan. Optionally fires events at step fire_at.
    task automatic scan(input logic [15:0] wr, input int fire_at,
                        input logic [1:0] mask, output logic [15:0] rd);
        rd = '0;
        for (int k = 0; k <= 18; k++) begin
            @(negedge tck);
            evt = (k == fire_at) ? mask : 2'b00;
            cap = (k == 0);
            shf = (k >= 1 && k <= 16);
            upd = (k == 17);
            if (k >= 1 && k <= 16) begin
                rd[16-k] = tdo;
                tdi = wr[16-k];
            end
        end
        idle(1);
    endtask

    task automatic fire(input logic [1:0] mask);
        @(negedge tck);
        evt = mask;
        idle(6);
    endtask

    task automatic t_reset();
        logic [15:0] rd;
        chk("R7 tdo after reset", {15'd0, tdo}, 16'h0000);
        status = 14'h0000;
        scan(16'h0000, -1, 2'b00, rd);
        chk("R7 flags clear after reset", rd, 16'h0000);
    endtask

    task automatic t_capture();
        logic [15:0] rd;
        status = 14'h2A5C;
        scan(16'h0000, -1, 2'b00, rd);
        chk("R1 status pattern A", rd, {14'h2A5C, 2'b00});
        status = 14'h1555;
        scan(16'h0000, -1, 2'b00, rd);
        chk("R1 status pattern B", rd, {14'h1555, 2'b00});
        status = 14'h3FFF;
        scan(16'h0000, -1, 2'b00, rd);
        chk("R1 R2 status all ones", rd, {14'h3FFF, 2'b00});
    endtask

    task automatic t_shift_hold();
        logic [15:0] rd;
        logic [15:0] back;
        status = 14'h0000;
        scan(16'hA5C0, -1, 2'b00, rd);
        idle(4);
        chk("R8 tdo held while idle", {15'd0, tdo}, 16'h0001);
        back = '0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge tck);
            shf = 1'b1;
            back[16-k] = tdo;
            tdi = 1'b0;
        end
        idle(1);
        chk("R2 shifted word replays MSB first", back, 16'hA5C0);
    endtask

    task automatic t_set_clear();
        logic [15:0] rd;
        status = 14'h0C33;
        fire(2'b01);
        scan(16'h0000, -1, 2'b00, rd);
        chk("R5 data-in flag set", rd, {14'h0C33, 2'b01});
        scan(16'h0000, -1, 2'b00, rd);
        chk("R4 zero write keeps flag", rd, {14'h0C33, 2'b01});
        fire(2'b10);
        scan(16'hFFFE, -1, 2'b00, rd);
        chk("R5 both flags set", rd, {14'h0C33, 2'b11});
        scan(16'h0000, -1, 2'b00, rd);
        chk("R3 R4 only data-out cleared, status unchanged", rd, {14'h0C33, 2'b01});
        scan(16'h0001, -1, 2'b00, rd);
        scan(16'h0000, -1, 2'b00, rd);
        chk("R3 data-in cleared", rd, {14'h0C33, 2'b00});
    endtask

    task automatic t_collision();
        logic [15:0] rd;
        status = 14'h0000;
        fire(2'b11);
        scan(16'h0003, 13, 2'b01, rd);
        scan(16'h0000, -1, 2'b00, rd);
        chk("R5 set before update is cleared", rd, 16'h0000);
        fire(2'b11);
        scan(16'h0003, 14, 2'b01, rd);
        scan(16'h0000, -1, 2'b00, rd);
        chk("R6 set on update edge wins", rd, 16'h0001);
        fire(2'b11);
        scan(16'h0003, 15, 2'b10, rd);
        scan(16'h0000, -1, 2'b00, rd);
        chk("R5 set after update survives", rd, 16'h0002);
        scan(16'h0003, -1, 2'b00, rd);
    endtask

    task automatic t_mid_reset();
        logic [15:0] rd;
        fire(2'b11);
        @(negedge tck);
        rst_n = 1'b0; core_rst_n = 1'b0;
        idle(3);
        chk("R7 tdo low in reset", {15'd0, tdo}, 16'h0000);
        rst_n = 1'b1; core_rst_n = 1'b1;
        idle(4);
        scan(16'h0000, -1, 2'b00, rd);
        chk("R7 reset dropped flags", rd, 16'h0000);
    endtask

    initial begin
        idle(4);
        @(negedge tck);
        rst_n = 1'b1; core_rst_n = 1'b1;
        idle(4);
        t_reset();
        t_capture();
        t_shift_hold();
        t_set_clear();
        t_collision();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: run incomplete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule